// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Usage and Modification Tracking

This block keeps a small set of page translations, each mapping a virtual page number to a physical frame number. Every memory access asks the block for a translation. The block compares the requested page number against all live entries at the same time. One clock later it reports a hit with the frame number, a miss, or a protection failure. A hit also marks the entry as recently used and, for a write, as modified. The block never walks page tables. A miss is handed back to a software handler, which installs the missing translation through a fill port. That port accepts writes only in privileged mode.

An epoch strobe clears every usage mark at once, which gives a coarse form of least-recently-used tracking. The fill logic takes the first free slot. If there is none, it takes the first slot not used since the last epoch, and if every slot has been used it takes slot 0. A flush input drops every translation in one cycle.

Top module: `pgmap_tlb`

## Requirements
- R1: A lookup driven in cycle N is answered in cycle N+1 with `resp_valid` high and exactly one of `resp_hit`, `resp_miss` or `resp_prot` high. When none of these apply, all four are low.
- R2: If no valid entry holds the requested page number, the answer is `resp_miss`, `resp_pfn` is zero, and no entry changes. `resp_pfn` is zero whenever `resp_hit` is low.
- R3: A hit returns the frame number stored with the matching entry. A successful hit or a fill sets that entry's used mark.
- R4: A write hit sets the entry's modified mark. `resp_dirty` reports the mark as it stands after the access. The mark stays set through later reads until a fill rewrites the slot, and a fill clears it.
- R5: A read (`lk_write`=0) needs the entry's read permission and a write (`lk_write`=1) needs its write permission. A failure gives `resp_prot` and zero frame, and leaves the used and modified marks unchanged.
- R6: A fill with `fill_priv` low changes nothing, and one cycle later it raises `fill_denied` with `fill_done` low.
- R7: An accepted fill writes the lowest-numbered invalid slot. If every slot is valid, it writes the lowest-numbered slot whose used mark is clear. If every mark is set, it writes slot 0. `fill_slot` reports the slot one cycle later, together with `fill_done`.
- R8: `epoch_clear` clears every used mark in one cycle.
- R9: `flush` invalidates every entry in one cycle. A fill presented in the same cycle is discarded, with no `fill_done`.
- R10: After reset all entries are invalid and every response and fill output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_write | input | 1 | Access is a write (1) or a read (0) |
| epoch_clear | input | 1 | Clear all used marks |
| flush | input | 1 | Invalidate all entries |
| fill_valid | input | 1 | Fill request |
| fill_priv | input | 1 | Requester is in privileged mode |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_rd | input | 1 | Read permission of the new entry |
| fill_wr | input | 1 | Write permission of the new entry |
| resp_valid | output | 1 | Lookup answer present |
| resp_hit | output | 1 | Translation found and permitted |
| resp_miss | output | 1 | Miss fault |
| resp_prot | output | 1 | Protection fault |
| resp_pfn | output | PFN_W | Translated frame number, zero unless hit |
| resp_dirty | output | 1 | Modified mark of the hit entry after this access |
| fill_done | output | 1 | Fill accepted |
| fill_slot | output | IDX_W | Slot written by the accepted fill |
| fill_denied | output | 1 | Fill refused: not privileged |

## Verification
The bench checks that a write blocked by permissions leaves the modified mark clear. A design that updated the marks before checking permissions would show `resp_dirty` on the next read. It walks replacement through all three tiers, using `fill_slot` after the table fills, after an epoch clear and after a flush. A design that ranked untouched slots ahead of invalid ones, or that failed to mark a slot as used on fill, would report the wrong slot. It also presents a fill and a flush in the same cycle, and a fill in user mode, then looks up the page to confirm that neither fill installed it. It probes neighbouring page numbers so that a partial tag compare would show up as a false hit.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  // outcome of one lookup, used by the response stage
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HIT  = 2'd1,
    LK_MISS = 2'd2,
    LK_PROT = 2'd3
  } lk_outcome_e;
endpackage

// File: rtl/pgmap_match.sv
module pgmap_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [VPN_W-1:0]              key_i,
  input  logic [ENTRIES-1:0]            live_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags_i,
  output logic                          any_o,
  output logic [IDX_W-1:0]              idx_o
);
  logic [ENTRIES-1:0] eq_vec;

  // one comparator per slot, all in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq_vec[g] = live_i[g] && (tags_i[g] == key_i);
  end

  assign any_o = |eq_vec;

  // lowest index wins if software ever installs a duplicate
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq_vec[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pgmap_victim.sv
module pgmap_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] live_i,
  input  logic [ENTRIES-1:0] used_i,
  output logic [IDX_W-1:0]   slot_o
);
  logic [IDX_W-1:0] free_idx, cold_idx;
  logic             free_any, cold_any;

  always_comb begin
    free_idx = '0;
    cold_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!live_i[i]) free_idx = IDX_W'(i);
      if (!used_i[i]) cold_idx = IDX_W'(i);
    end
  end

  assign free_any = ~&live_i;
  assign cold_any = ~&used_i;

  // tiers: free slot, then unused slot, then slot 0
  assign slot_o = free_any ? free_idx : (cold_any ? cold_idx : '0);
endmodule

// File: rtl/pgmap_tlb.sv
module pgmap_tlb
  import pgmap_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_write,
  input  logic             epoch_clear,
  input  logic             flush,
  input  logic             fill_valid,
  input  logic             fill_priv,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_rd,
  input  logic             fill_wr,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_miss,
  output logic             resp_prot,
  output logic [PFN_W-1:0] resp_pfn,
  output logic             resp_dirty,
  output logic             fill_done,
  output logic [IDX_W-1:0] fill_slot,
  output logic             fill_denied
);
  // per-slot status flags
  logic [ENTRIES-1:0] live_q, used_q, mod_q, perm_r_q, perm_w_q;
  // tag and frame storage, written only by fills, no reset
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0] frame_q;

  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] victim;
  logic             perm_ok, acc_ok, fill_go;
  lk_outcome_e      outcome;

  pgmap_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .key_i  (lk_vpn),
    .live_i (live_q),
    .tags_i (tag_q),
    .any_o  (hit_any),
    .idx_o  (hit_idx)
  );

  pgmap_victim #(.ENTRIES(ENTRIES)) u_victim (
    .live_i (live_q),
    .used_i (used_q),
    .slot_o (victim)
  );

  assign perm_ok = lk_write ? perm_w_q[hit_idx] : perm_r_q[hit_idx];
  assign fill_go = fill_valid && fill_priv && !flush;

  always_comb begin
    if (!lk_valid)    outcome = LK_IDLE;
    else if (!hit_any) outcome = LK_MISS;
    else if (!perm_ok) outcome = LK_PROT;
    else               outcome = LK_HIT;
  end
  assign acc_ok = (outcome == LK_HIT);

  // status flags; later statements take precedence
  always_ff @(posedge clk) begin
    if (rst) begin
      live_q   <= '0;
      used_q   <= '0;
      mod_q    <= '0;
      perm_r_q <= '0;
      perm_w_q <= '0;
    end else begin
      if (epoch_clear) used_q <= '0;
      if (acc_ok) begin
        used_q[hit_idx] <= 1'b1;
        if (lk_write) mod_q[hit_idx] <= 1'b1;
      end
      if (flush) begin
        live_q <= '0;
      end else if (fill_go) begin
        live_q[victim]   <= 1'b1;
        used_q[victim]   <= 1'b1;
        mod_q[victim]    <= 1'b0;
        perm_r_q[victim] <= fill_rd;
        perm_w_q[victim] <= fill_wr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[victim]   <= fill_vpn;
      frame_q[victim] <= fill_pfn;
    end
  end

  // registered responses
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_miss   <= 1'b0;
      resp_prot   <= 1'b0;
      resp_pfn    <= '0;
      resp_dirty  <= 1'b0;
      fill_done   <= 1'b0;
      fill_slot   <= '0;
      fill_denied <= 1'b0;
    end else begin
      resp_valid  <= (outcome != LK_IDLE);
      resp_hit    <= acc_ok;
      resp_miss   <= (outcome == LK_MISS);
      resp_prot   <= (outcome == LK_PROT);
      resp_pfn    <= acc_ok ? frame_q[hit_idx] : '0;
      resp_dirty  <= acc_ok && (mod_q[hit_idx] || lk_write);
      fill_done   <= fill_go;
      fill_slot   <= fill_go ? victim : '0;
      fill_denied <= fill_valid && !fill_priv;
    end
  end
endmodule

// File: rtl/pgmap_tlb_chk.sv
module pgmap_tlb_chk #(
  parameter int PFN_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             lk_write,
  input logic             flush,
  input logic             fill_valid,
  input logic             fill_priv,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic             resp_miss,
  input logic             resp_prot,
  input logic [PFN_W-1:0] resp_pfn,
  input logic             resp_dirty,
  input logic             fill_done,
  input logic             fill_denied
);
  // R1
  lookup_answered_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> resp_valid);
  // R1
  single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($countones({resp_hit, resp_miss, resp_prot}) == 1));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> !(resp_hit || resp_miss || resp_prot));
  // R2
  pfn_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !resp_hit |-> (resp_pfn == '0));
  // R4
  write_marks_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_write) |=> (resp_hit |-> resp_dirty));
  // R4
  dirty_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    resp_dirty |-> resp_hit);
  // R6
  user_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !fill_priv) |=> (fill_denied && !fill_done));
  // R9
  flush_wins_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !fill_done);
endmodule

bind pgmap_tlb pgmap_tlb_chk #(.PFN_W(PFN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lk_valid    (lk_valid),
  .lk_write    (lk_write),
  .flush       (flush),
  .fill_valid  (fill_valid),
  .fill_priv   (fill_priv),
  .resp_valid  (resp_valid),
  .resp_hit    (resp_hit),
  .resp_miss   (resp_miss),
  .resp_prot   (resp_prot),
  .resp_pfn    (resp_pfn),
  .resp_dirty  (resp_dirty),
  .fill_done   (fill_done),
  .fill_denied (fill_denied)
);

// File: tb/pgmap_tlb_tb.sv
module pgmap_tlb_tb;
  localparam int ENTRIES = 16;
  localparam int VPN_W   = 20;
  localparam int PFN_W   = 20;
  localparam int IDX_W   = 4;

  // expected kinds: 0 hit, 1 miss, 2 protection fault
  typedef struct packed {
    logic [19:0] vpn;
    logic        wr;
    logic [1:0]  kind;
    logic [19:0] pfn;
    logic        dirty;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{20'h12345, 1'b0, 2'd0, 20'h0AAAA, 1'b0, 8'd3},
    '{20'h12345, 1'b1, 2'd0, 20'h0AAAA, 1'b1, 8'd4},
    '{20'h12345, 1'b0, 2'd0, 20'h0AAAA, 1'b1, 8'd4},
    '{20'h00001, 1'b0, 2'd0, 20'h00B0B, 1'b0, 8'd3},
    '{20'h00001, 1'b1, 2'd2, 20'h00000, 1'b0, 8'd5},
    '{20'h00001, 1'b0, 2'd0, 20'h00B0B, 1'b0, 8'd5},
    '{20'h80000, 1'b0, 2'd2, 20'h00000, 1'b0, 8'd5},
    '{20'h12344, 1'b0, 2'd1, 20'h00000, 1'b0, 8'd2},
    '{20'hFFFFF, 1'b1, 2'd0, 20'hC0C0C, 1'b1, 8'd3},
    '{20'h00000, 1'b0, 2'd1, 20'h00000, 1'b0, 8'd2}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lk_valid = 1'b0, lk_write = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic             epoch_clear = 1'b0, flush = 1'b0;
  logic             fill_valid = 1'b0, fill_priv = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic             resp_valid, resp_hit, resp_miss, resp_prot, resp_dirty;
  logic [PFN_W-1:0] resp_pfn;
  logic             fill_done, fill_denied;
  logic [IDX_W-1:0] fill_slot;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pgmap_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write),
    .epoch_clear(epoch_clear), .flush(flush), .fill_valid(fill_valid),
    .fill_priv(fill_priv), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_rd(fill_rd), .fill_wr(fill_wr), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_prot(resp_prot),
    .resp_pfn(resp_pfn), .resp_dirty(resp_dirty), .fill_done(fill_done),
    .fill_slot(fill_slot), .fill_denied(fill_denied)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic do_lookup(input logic [19:0] v, input logic w);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_write = w;
    @(negedge clk);
    lk_valid = 1'b0; lk_write = 1'b0;
  endtask

  // kind: 0 hit, 1 miss, 2 prot
  task automatic expect_lk(input string req, input logic [19:0] v, input logic w,
                           input int kind, input logic [19:0] pfn, input logic d);
    do_lookup(v, w);
    chk(req, "resp_valid", 32'(resp_valid), 32'd1);
    chk(req, "resp_hit",   32'(resp_hit),   32'(kind == 0));
    chk(req, "resp_miss",  32'(resp_miss),  32'(kind == 1));
    chk(req, "resp_prot",  32'(resp_prot),  32'(kind == 2));
    chk(req, "resp_pfn",   32'(resp_pfn),   32'(pfn));
    chk(req, "resp_dirty", 32'(resp_dirty), 32'(d));
  endtask

  task automatic do_fill(input logic [19:0] v, input logic [19:0] p,
                         input logic r, input logic w, input logic pr, input logic fl);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_pfn = p; fill_rd = r; fill_wr = w;
    fill_priv = pr; flush = fl;
    @(negedge clk);
    fill_valid = 1'b0; fill_priv = 1'b0; flush = 1'b0;
  endtask

  task automatic expect_fill(input string req, input logic [19:0] v,
                             input logic [19:0] p, input logic r, input logic w,
                             input int slot);
    do_fill(v, p, r, w, 1'b1, 1'b0);
    chk(req, "fill_done", 32'(fill_done), 32'd1);
    chk(req, "fill_slot", 32'(fill_slot), 32'(slot));
  endtask

  task automatic pulse_epoch();
    @(negedge clk); epoch_clear = 1'b1;
    @(negedge clk); epoch_clear = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10", "resp_valid",  32'(resp_valid),  32'd0);
    chk("R10", "fill_done",   32'(fill_done),   32'd0);
    chk("R10", "fill_denied", 32'(fill_denied), 32'd0);
    chk("R10", "resp_pfn",    32'(resp_pfn),    32'd0);
    expect_lk("R10", 20'h00005, 1'b0, 1, 20'h0, 1'b0);

    // R7 empty table fills in slot order; R3 entries for the table
    expect_fill("R7", 20'h12345, 20'h0AAAA, 1'b1, 1'b1, 0);
    expect_fill("R7", 20'h00001, 20'h00B0B, 1'b1, 1'b0, 1);
    expect_fill("R7", 20'hFFFFF, 20'hC0C0C, 1'b1, 1'b1, 2);
    expect_fill("R7", 20'h80000, 20'h0DDDD, 1'b0, 1'b0, 3);

    // vector table: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      expect_lk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].vpn, VECS[i].wr,
                int'(VECS[i].kind), VECS[i].pfn, VECS[i].dirty);
    end

    // R6 user-mode fill refused and leaves nothing behind
    do_fill(20'h33333, 20'h03333, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6", "fill_denied", 32'(fill_denied), 32'd1);
    chk("R6", "fill_done",   32'(fill_done),   32'd0);
    expect_lk("R6", 20'h33333, 1'b0, 1, 20'h0, 1'b0);

    // R7 fill the rest; slot 4 proves the refused fill took nothing
    for (int i = 4; i < ENTRIES; i++) begin
      expect_fill("R7", 20'h00100 + 20'(i), 20'h50000 + 20'(i), 1'b1, 1'b1, i);
    end
    // R7 all valid, all used: slot 0 is replaced
    expect_fill("R7", 20'h22222, 20'h02222, 1'b1, 1'b1, 0);
    expect_lk("R7", 20'h12345, 1'b0, 1, 20'h0, 1'b0);
    expect_lk("R3", 20'h22222, 1'b0, 0, 20'h02222, 1'b0);

    // R8 epoch clear, then touch slots 0 and 1 only
    pulse_epoch();
    expect_lk("R8", 20'h22222, 1'b0, 0, 20'h02222, 1'b0);
    expect_lk("R8", 20'h00001, 1'b0, 0, 20'h00B0B, 1'b0);
    expect_fill("R8", 20'h44444, 20'h04444, 1'b1, 1'b1, 2);
    expect_fill("R3", 20'h55555, 20'h05555, 1'b1, 1'b1, 3);
    // R4 refill clears the modified mark of slot 2
    expect_lk("R4", 20'h44444, 1'b0, 0, 20'h04444, 1'b0);

    // R9 flush with a same-cycle fill: fill discarded, table empty
    do_fill(20'h66666, 20'h06666, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R9", "fill_done", 32'(fill_done), 32'd0);
    expect_lk("R9", 20'h66666, 1'b0, 1, 20'h0, 1'b0);
    expect_lk("R9", 20'h00001, 1'b0, 1, 20'h0, 1'b0);
    // R7 invalid slots beat untouched ones after a flush
    expect_fill("R7", 20'h77777, 20'h07777, 1'b1, 1'b1, 0);
    expect_fill("R7", 20'h88888, 20'h08888, 1'b1, 1'b1, 1);
    pulse_flush();
    expect_lk("R9", 20'h77777, 1'b0, 1, 20'h0, 1'b0);

    // R1 idle after a lookup
    @(negedge clk);
    chk("R1", "resp_valid idle", 32'(resp_valid), 32'd0);
    summary();
  end
endmodule